// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a vector of input pins for a change of level in either direction and reports it as an interrupt per group. The pins are split into groups of eight. Each group has a mask register that picks which of its pins take part, a sticky flag that records that a picked pin changed, and an enable bit that gates the flag onto the group's interrupt request line. The default build has three groups over 24 pin positions. Position 15 has no pin, so it never contributes.

On the clocked path a change crosses a fixed pipeline before it reaches the flag. The stages are an input capture stage, a synchronizer, a masked compare against the previous synchronized value, a registered group change, a set pulse, and then the flag. Because the pins are only observed, software can raise an interrupt by driving a pin that is set as an output. A separate combinational wake output compares the raw pins with the last synchronized values through the masks. It therefore signals a change while the clock is stopped, for use by a sleep controller.

Software writes the masks and enables through a small register port. It clears flags by pulsing their bits on a clear input.

Top module: `pin_change_irq`

## Requirements
- R1: After a synchronous active-low reset, all masks, all enable bits, all flags, all interrupt requests and the wake output are zero.
- R2: Register address g (0..2) holds the mask of group g. Bit i of that mask enables pin 8g+i. Address 3 holds the group enables in bits [2:0], with bit g for group g. A write takes effect at the clock edge where reg_we is 1. reg_rdata shows the addressed register combinationally.
- R3: Pin position 15 (group 1, mask bit 7) does not exist. Its mask bit always reads 0, and toggling pin 15 never sets a flag or raises wake.
- R4: A rising or a falling change on a pin whose mask bit is 1 sets the flag of that pin's group.
- R5: A change on a pin whose mask bit is 0 does not set any flag.
- R6: A change applied between two clock edges shows in the flag after the fifth rising edge that follows, and not after the fourth.
- R7: Each group's flag responds only to changes on its own pins. Changes in several groups in the same cycle set each of those groups' flags.
- R8: A set flag holds until a clock edge at which its flag_clr bit is 1, and that edge clears it.
- R9: When a set pulse and a clear for the same flag arrive at the same edge, the flag ends up set.
- R10: irq[g] equals flag[g] AND enable bit g.
- R11: wake is 1, with no clock edge needed, while some masked-in pin differs from its synchronized value. It returns to 0 once the synchronizer has taken the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins | input | 24 | Observed pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0..2 masks, 3 enables) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| flag_clr | input | 3 | Write-1 flag clear, one bit per group |
| flag | output | 3 | Sticky change flags, one per group |
| irq | output | 3 | Interrupt requests, flag gated by enable |
| wake | output | 1 | Asynchronous change indication |

## Verification
The hardest case to reach from the ports is a set and a clear landing on the same flag at the same edge. The set pulse exists for only one cycle, five edges after a pin change. To get there, the bench first sets the flag with one toggle and then toggles the pin again. It counts four edges from that point and holds flag_clr high across the fifth edge alone. Reaching the wake output is also a matter of timing: the bench samples it between the pin change and the first edge, which is the only window in which the clocked path has not yet seen the change.

// File: rtl/pcirq_pkg.sv
// Package: shared sizing defaults for the grouped pin-change interrupt block.
// Assumes groups are of equal width and the enable register fits one data word.
package pcirq_pkg;
    localparam int DEF_GROUPS  = 3;
    localparam int DEF_GROUP_W = 8;
    // Pin positions that physically exist; position 15 is absent.
    localparam logic [DEF_GROUPS*DEF_GROUP_W-1:0] DEF_PRESENT = 24'hFF7FFF;
endpackage

// File: rtl/pcirq_regs.sv
// Module: mask and enable registers with a combinational read port.
// Assumes NUM_GROUPS <= GROUP_W so the enable register fits one data word.
// Mask bits of absent pin positions are forced to zero on write.
module pcirq_regs #(
    parameter int NUM_GROUPS = 3,
    parameter int GROUP_W    = 8,
    parameter int ADDR_W     = 2,
    parameter logic [NUM_GROUPS*GROUP_W-1:0] PIN_PRESENT = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [GROUP_W-1:0]            wdata,
    output logic [GROUP_W-1:0]            rdata,
    output logic [NUM_GROUPS*GROUP_W-1:0] mask,
    output logic [NUM_GROUPS-1:0]         enable
);
    localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(NUM_GROUPS);

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_mask
            // Holds the mask of group g, dropping absent pin positions.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mask[g*GROUP_W +: GROUP_W] <= '0;
                else if (we && addr == ADDR_W'(g))
                    mask[g*GROUP_W +: GROUP_W] <= wdata & PIN_PRESENT[g*GROUP_W +: GROUP_W];
            end
        end
    endgenerate

    // Holds the per-group interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= '0;
        else if (we && addr == EN_ADDR)
            enable <= wdata[NUM_GROUPS-1:0];
    end

    // Selects the addressed register for reading.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_GROUPS; i++)
            if (addr == ADDR_W'(i))
                rdata = mask[i*GROUP_W +: GROUP_W];
        if (addr == EN_ADDR)
            rdata[NUM_GROUPS-1:0] = enable;
    end
endmodule

// File: rtl/pcirq_detect.sv
// Module: change-detect pipeline plus asynchronous wake compare.
// Stages: capture, synchronize, masked compare with history, registered group
// change, set pulse. Assumes pins may be asynchronous to clk.
module pcirq_detect #(
    parameter int NUM_GROUPS = 3,
    parameter int GROUP_W    = 8,
    parameter logic [NUM_GROUPS*GROUP_W-1:0] PIN_PRESENT = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*GROUP_W-1:0] pins,
    input  logic [NUM_GROUPS*GROUP_W-1:0] mask,
    output logic [NUM_GROUPS-1:0]         set_pulse,
    output logic                          wake
);
    localparam int NUM_PINS = NUM_GROUPS * GROUP_W;

    logic [NUM_PINS-1:0]   pin_cap, pin_sync, pin_hist, pin_chg, mask_eff;
    logic [NUM_GROUPS-1:0] grp_chg, grp_chg_q;

    assign mask_eff = mask & PIN_PRESENT;

    // Captures, synchronizes and remembers the previous synchronized pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_cap  <= '0;
            pin_sync <= '0;
            pin_hist <= '0;
        end else begin
            pin_cap  <= pins;
            pin_sync <= pin_cap;
            pin_hist <= pin_sync;
        end
    end

    // Marks masked pins whose synchronized level moved in either direction.
    always_comb pin_chg = (pin_sync ^ pin_hist) & mask_eff;

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_or
            assign grp_chg[g] = |pin_chg[g*GROUP_W +: GROUP_W];
        end
    endgenerate

    // Registers the group change, then forms the one-cycle set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_chg_q <= '0;
            set_pulse <= '0;
        end else begin
            grp_chg_q <= grp_chg;
            set_pulse <= grp_chg_q;
        end
    end

    // Flags a pending change without needing a clock edge.
    always_comb wake = |((pins ^ pin_sync) & mask_eff);
endmodule

// File: rtl/pcirq_flags.sv
// Module: sticky per-group flags and gated interrupt requests.
// Assumes set_pulse is one cycle wide; a set beats a clear at the same edge.
module pcirq_flags #(
    parameter int NUM_GROUPS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] set_pulse,
    input  logic [NUM_GROUPS-1:0] clr,
    input  logic [NUM_GROUPS-1:0] enable,
    output logic [NUM_GROUPS-1:0] flag,
    output logic [NUM_GROUPS-1:0] irq
);
    // Keeps flags until cleared, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= '0;
        else
            flag <= (flag & ~clr) | set_pulse;
    end

    // Gates each flag with its enable.
    always_comb irq = flag & enable;
endmodule

// File: rtl/pin_change_irq.sv
// Module: top of the grouped pin-change interrupt controller.
// Assumes synchronous active-low reset and NUM_GROUPS <= GROUP_W.
module pin_change_irq
    import pcirq_pkg::*;
#(
    parameter int NUM_GROUPS = DEF_GROUPS,
    parameter int GROUP_W    = DEF_GROUP_W,
    parameter logic [NUM_GROUPS*GROUP_W-1:0] PIN_PRESENT = DEF_PRESENT,
    localparam int NUM_PINS  = NUM_GROUPS * GROUP_W,
    localparam int ADDR_W    = $clog2(NUM_GROUPS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pins,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [GROUP_W-1:0]    reg_wdata,
    output logic [GROUP_W-1:0]    reg_rdata,
    input  logic [NUM_GROUPS-1:0] flag_clr,
    output logic [NUM_GROUPS-1:0] flag,
    output logic [NUM_GROUPS-1:0] irq,
    output logic                  wake
);
    logic [NUM_PINS-1:0]   mask;
    logic [NUM_GROUPS-1:0] irq_en;
    logic [NUM_GROUPS-1:0] set_pulse;

    pcirq_regs #(
        .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W),
        .ADDR_W(ADDR_W), .PIN_PRESENT(PIN_PRESENT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .mask(mask), .enable(irq_en)
    );

    pcirq_detect #(
        .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .PIN_PRESENT(PIN_PRESENT)
    ) u_detect (
        .clk(clk), .rst_n(rst_n), .pins(pins), .mask(mask),
        .set_pulse(set_pulse), .wake(wake)
    );

    pcirq_flags #(
        .NUM_GROUPS(NUM_GROUPS)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .clr(flag_clr),
        .enable(irq_en), .flag(flag), .irq(irq)
    );
endmodule

// File: rtl/pcirq_checker.sv
// Module: property checker for the flag logic, bound into the top module.
// Assumes synchronous active-low reset.
module pcirq_checker #(
    parameter int NUM_GROUPS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_GROUPS-1:0] set_pulse,
    input logic [NUM_GROUPS-1:0] flag_clr,
    input logic [NUM_GROUPS-1:0] flag,
    input logic [NUM_GROUPS-1:0] irq,
    input logic [NUM_GROUPS-1:0] irq_en
);
    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_chk
            AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                set_pulse[g] |=> flag[g]); // R9
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                flag[g] && !flag_clr[g] |=> flag[g]); // R8
            AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
                flag[g] && flag_clr[g] && !set_pulse[g] |=> !flag[g]); // R8
            AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
                !flag[g] && !set_pulse[g] |=> !flag[g]); // R6
            AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
                irq[g] == (flag[g] && irq_en[g])); // R10
        end
    endgenerate
endmodule

bind pin_change_irq pcirq_checker #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .flag_clr(flag_clr),
    .flag(flag), .irq(irq), .irq_en(irq_en)
);

// File: tb/tb_pin_change_irq.sv
module tb_pin_change_irq;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // Each entry: {mask[23:0], toggle[23:0], expected flags[2:0]}
    localparam logic [50:0] VEC [NV] = '{
        {24'hFFFFFF, 24'h000001, 3'b001},  // R4 rising pin 0
        {24'hFFFFFF, 24'h000001, 3'b001},  // R4 falling pin 0
        {24'h000000, 24'hFFFFFF, 3'b000},  // R5 all masked off
        {24'h00FF00, 24'hFF00FF, 3'b000},  // R5 toggles outside mask
        {24'hFFFFFF, 24'h800000, 3'b100},  // R7 group 2 only
        {24'hFFFFFF, 24'h008000, 3'b000},  // R3 absent pin 15
        {24'h010100, 24'h010100, 3'b110},  // R7 two groups at once
        {24'hFFFFFF, 24'h000F00, 3'b010}   // R7 group 1 only
    };

    logic        clk = 0, rst_n = 0, reg_we = 0, wake;
    logic [23:0] pins = '0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic [2:0]  flag_clr = '0, flag, irq;
    int checks = 0, failures = 0;

    pin_change_irq dut (
        .clk(clk), .rst_n(rst_n), .pins(pins), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flag_clr(flag_clr), .flag(flag), .irq(irq), .wake(wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_we = 0;
    endtask

    task automatic clr_all();
        flag_clr = 3'b111;
        tick(1);
        flag_clr = 3'b000;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 flag", flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wake", wake, 0);
        rst_n = 1;
        tick(1);
        for (int a = 0; a < 4; a++) begin
            reg_addr = a[1:0];
            #1 chk("R1 reg", reg_rdata, 0);
        end

        // R2 register readback, R3 absent mask bit
        wr(2'd0, 8'hA5); wr(2'd1, 8'hFF); wr(2'd2, 8'h3C); wr(2'd3, 8'h06);
        reg_addr = 2'd0; #1 chk("R2 mask0", reg_rdata, 8'hA5);
        reg_addr = 2'd1; #1 chk("R3 mask1 bit7", reg_rdata, 8'h7F);
        reg_addr = 2'd2; #1 chk("R2 mask2", reg_rdata, 8'h3C);
        reg_addr = 2'd3; #1 chk("R2 enable", reg_rdata, 8'h06);
        wr(2'd3, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [23:0] m, t;
            logic [2:0]  e;
            {m, t, e} = VEC[i];
            wr(2'd0, m[7:0]); wr(2'd1, m[15:8]); wr(2'd2, m[23:16]);
            clr_all();
            pins = pins ^ t;
            tick(7);
            chk($sformatf("R4/R5/R7/R3 vector %0d", i), flag, e);
        end
        clr_all();

        // R6 latency: masks are all ones here
        pins[0] = ~pins[0];
        tick(4);
        chk("R6 not after 4 edges", flag, 3'b000);
        tick(1);
        chk("R6 after 5 edges", flag, 3'b001);

        // R8 hold then clear
        tick(10);
        chk("R8 hold", flag, 3'b001);
        flag_clr = 3'b001; tick(1); flag_clr = 3'b000;
        chk("R8 cleared", flag, 3'b000);

        // R9 set beats clear
        pins[0] = ~pins[0];
        tick(5);
        chk("R9 setup", flag, 3'b001);
        pins[0] = ~pins[0];
        tick(4);
        flag_clr = 3'b001; tick(1); flag_clr = 3'b000;
        chk("R9 set wins", flag, 3'b001);
        clr_all();
        chk("R9 then clears", flag, 3'b000);

        // R10 irq gating
        wr(2'd3, 8'h01);
        pins[0] = ~pins[0]; pins[8] = ~pins[8];
        tick(6);
        chk("R10 flags", flag, 3'b011);
        chk("R10 irq en=001", irq, 3'b001);
        wr(2'd3, 8'h03);
        chk("R10 irq en=011", irq, 3'b011);
        wr(2'd3, 8'h00);
        chk("R10 irq en=000", irq, 3'b000);
        clr_all();

        // R11 wake: combinational, then falls after synchronizer
        pins[2] = ~pins[2];
        #1 chk("R11 wake high", wake, 1);
        tick(3);
        chk("R11 wake low", wake, 0);
        wr(2'd2, 8'h00);
        pins[20] = ~pins[20];
        #1 chk("R11 masked no wake", wake, 0);
        tick(3);
        pins[15] = ~pins[15];
        #1 chk("R3 pin15 no wake", wake, 0);
        tick(6);
        chk("R3 pin15 no flag1", flag[1], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule